// File: doc/BRIEF.md
# Saturating Line-Error Counter Bank

This block holds four error counters for a T1 receive monitor: bipolar violations, CRC word errors, out-of-frame events and frame-bit errors. Each counter takes a one-cycle accepted-event strobe from the framer logic, counts up from a value the host preset, and stops at full scale. The host can set a threshold this way: it presets a counter to full scale minus N, and the (N+1)-th event flags an interrupt.

Events that arrive while a counter sits at full scale set a sticky saturation bit. A mask selects which sticky bits drive the interrupt line. Events from the CRC, out-of-frame and frame-bit sources are gated by loss of sync and by the framing mode (superframe or extended superframe). An optional clear-on-read mode zeroes all four counts on any host read without losing an event that lands in the same cycle.

Host access is a register-style port. The address map is 0 for the violation count high byte, 1 for the violation count low byte, 2 for CRC, 3 for out-of-frame, 4 for frame-bit errors and 5 for the sticky status. Status bits are bit0 violation, bit1 CRC, bit2 out-of-frame and bit3 frame-bit. Any other address reads as 0.

Top module: `line_err_counters`

## Requirements
- R1: The violation counter is 16 bits and holds at 65535; the other three are 8 bits and hold at 255; an event at full scale never wraps the count.
- R2: Each accepted event raises its counter by exactly one from its current or preset value.
- R3: An accepted event that finds its counter at full scale sets that counter's sticky status bit (bit0 violation, bit1 CRC, bit2 out-of-frame, bit3 frame-bit). Sticky bits stay set until a read of address 5 clears them; a hit in that same cycle survives the clear.
- R4: `irq` is high exactly when some sticky bit is set whose `irq_mask` bit is 1.
- R5: With `auto_clr` high, any register read clears all four counters; an event accepted in that cycle leaves its counter at 1. With `auto_clr` low, reads leave counts unchanged.
- R6: A write to address 1 only stages a low byte. A write to address 0 loads the violation counter with {written byte, staged byte}.
- R7: A read of address 0 returns the violation count high byte and latches its low byte; a read of address 1 returns that latched byte, not the live count.
- R8: The violation counter counts while `los` is high; the CRC, out-of-frame and frame-bit counters ignore events while `los` is high.
- R9: With `esf_mode` low, the CRC counter is held at 0, and its events and writes have no effect.
- R10: The frame-bit counter counts `evt_fe_main` in both modes. In superframe mode (`esf_mode`=0) it also counts `evt_fe_sig` when `fe_both` is 1; in extended superframe mode `evt_fe_sig` is ignored.
- R11: A host write to a counter in the same cycle as one of its events loads the written value and drops that event.
- R12: Read data appears on `reg_rdata` the cycle after `reg_rd`, holds until the next read, shows the value before that cycle's event, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_bpv | input | 1 | Bipolar violation event strobe |
| evt_crc | input | 1 | CRC word error event strobe |
| evt_oof | input | 1 | Out-of-frame event strobe |
| evt_fe_main | input | 1 | Terminal framing (or FPS) bit error strobe |
| evt_fe_sig | input | 1 | Signalling framing bit error strobe |
| los | input | 1 | Loss of sync |
| esf_mode | input | 1 | 1 = extended superframe, 0 = superframe |
| fe_both | input | 1 | Count signalling framing errors in superframe mode |
| auto_clr | input | 1 | Clear all counters on any read |
| irq_mask | input | 4 | Interrupt enable per sticky bit |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Host register address |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The bench presets counters just below full scale and pushes them over the edge. A wrapping counter would read back a small value, and a missing flag would leave status and `irq` quiet. It lines up an event with a write, with a plain read and with a clear-on-read. A design that dropped the event would read 0 instead of 1 after the clear, and one with the wrong priority would read the write value plus one. It runs the two-byte preset and readback with an event between the two reads. Loading the low byte at once, or reading it live, shows up as a changed or torn value. It also sweeps loss of sync, framing mode and the signalling-error option, so a wrong gate shows up as a count that moves when it should not.

// File: rtl/lec_pkg.sv
package lec_pkg;
  localparam int unsigned LEC_N    = 4;
  localparam int unsigned IX_BPV   = 0;
  localparam int unsigned IX_CRC   = 1;
  localparam int unsigned IX_OOF   = 2;
  localparam int unsigned IX_FE    = 3;
  localparam int unsigned LEC_BYTE = 8;
  localparam int unsigned LEC_SLOT = 16;

  typedef enum logic [2:0] {
    A_BPV_HI = 3'd0,
    A_BPV_LO = 3'd1,
    A_CRC    = 3'd2,
    A_OOF    = 3'd3,
    A_FE     = 3'd4,
    A_STAT   = 3'd5
  } lec_addr_e;

  // all-ones value of a w-bit counter, in a 16-bit slot
  function automatic logic [LEC_SLOT-1:0] lec_full(input int unsigned w);
    lec_full = LEC_SLOT'((32'd1 << w) - 32'd1);
  endfunction

  // next value of a saturating counter
  function automatic logic [LEC_SLOT-1:0] lec_advance(input logic [LEC_SLOT-1:0] base,
                                                      input logic [LEC_SLOT-1:0] full);
    lec_advance = (base == full) ? base : base + 16'd1;
  endfunction

  // an event at full scale is an overflow hit
  function automatic logic lec_overflows(input logic [LEC_SLOT-1:0] base,
                                         input logic [LEC_SLOT-1:0] full,
                                         input logic ev);
    lec_overflows = ev && (base == full);
  endfunction
endpackage

// File: rtl/lec_evt_gate.sv
module lec_evt_gate
  import lec_pkg::*;
(
  input  logic             evt_bpv,
  input  logic             evt_crc,
  input  logic             evt_oof,
  input  logic             evt_fe_main,
  input  logic             evt_fe_sig,
  input  logic             los,
  input  logic             esf_mode,
  input  logic             fe_both,
  output logic [LEC_N-1:0] acc,
  output logic             crc_hold
);
  logic fe_sig_ok;

  // signalling framing errors only count in superframe mode when enabled
  assign fe_sig_ok   = evt_fe_sig & fe_both & ~esf_mode;

  assign acc[IX_BPV] = evt_bpv;
  assign acc[IX_CRC] = evt_crc & esf_mode & ~los;
  assign acc[IX_OOF] = evt_oof & ~los;
  assign acc[IX_FE]  = ~los & (evt_fe_main | fe_sig_ok);
  assign crc_hold    = ~esf_mode;
endmodule

// File: rtl/lec_sat_counter.sv
module lec_sat_counter
  import lec_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         clr,
  input  logic         evt,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         hit
);
  localparam logic [LEC_SLOT-1:0] FULL16 = lec_full(W);
  localparam logic [W-1:0]        FULL   = W'(FULL16);

  logic [W-1:0] base;
  logic [W-1:0] nxt;

  always_comb begin
    base = clr ? '0 : q;
    hit  = 1'b0;
    if (hold) begin
      nxt = '0;
    end else if (ld) begin
      nxt = ld_val;
    end else if (evt) begin
      hit = lec_overflows(LEC_SLOT'(base), FULL16, 1'b1);
      nxt = W'(lec_advance(LEC_SLOT'(base), FULL16));
    end else begin
      nxt = base;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assert_no_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q == FULL && evt && !ld && !clr && !hold) |=> (q == FULL));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !ld && !clr && !hold && q != FULL) |=> (q == W'($past(q) + 1'b1)));

  assert_hit_at_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (q == FULL && !clr && !ld && !hold));

  assert_clr_keeps_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt && !ld && !hold) |=> (q == W'(1)));

  assert_hold_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (q == '0));

  assert_ld_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !hold) |=> (q == $past(ld_val)));
endmodule

// File: rtl/lec_host_regs.sv
module lec_host_regs
  import lec_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [2:0]                     addr,
  input  logic [LEC_BYTE-1:0]            wdata,
  input  logic                           auto_clr,
  input  logic [LEC_SLOT-1:0]            bpv_q,
  input  logic [LEC_N-2:0][LEC_BYTE-1:0] err_q,
  input  logic [LEC_N-1:0]               hits,
  output logic [LEC_N-1:0]               ld,
  output logic [LEC_SLOT-1:0]            ld_bpv_val,
  output logic [LEC_BYTE-1:0]            ld_byte,
  output logic                           rd_clr,
  output logic [LEC_BYTE-1:0]            rdata,
  output logic [LEC_N-1:0]               sticky
);
  lec_addr_e           a;
  logic [LEC_BYTE-1:0] stage_lo;
  logic [LEC_BYTE-1:0] shadow_lo;
  logic [LEC_BYTE-1:0] rd_val;
  logic                stat_rd;

  assign a          = lec_addr_e'(addr);
  assign stat_rd    = rd && (a == A_STAT);
  assign rd_clr     = rd && auto_clr;
  assign ld_bpv_val = {wdata, stage_lo};
  assign ld_byte    = wdata;

  always_comb begin
    ld         = '0;
    ld[IX_BPV] = wr && (a == A_BPV_HI);
    ld[IX_CRC] = wr && (a == A_CRC);
    ld[IX_OOF] = wr && (a == A_OOF);
    ld[IX_FE]  = wr && (a == A_FE);
  end

  always_comb begin
    case (a)
      A_BPV_HI: rd_val = bpv_q[LEC_SLOT-1:LEC_BYTE];
      A_BPV_LO: rd_val = shadow_lo;
      A_CRC:    rd_val = err_q[IX_CRC-1];
      A_OOF:    rd_val = err_q[IX_OOF-1];
      A_FE:     rd_val = err_q[IX_FE-1];
      A_STAT:   rd_val = LEC_BYTE'(sticky);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_lo  <= '0;
      shadow_lo <= '0;
      rdata     <= '0;
      sticky    <= '0;
    end else begin
      if (wr && a == A_BPV_LO) stage_lo <= wdata;
      if (rd) begin
        rdata <= rd_val;
        if (a == A_BPV_HI) shadow_lo <= bpv_q[LEC_BYTE-1:0];
      end
      sticky <= (stat_rd ? '0 : sticky) | hits;
    end
  end

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((sticky & $past(sticky)) == $past(sticky)));

  assert_hit_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|hits) |=> ((sticky & $past(hits)) == $past(hits)));

  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/line_err_counters.sv
module line_err_counters
  import lec_pkg::*;
#(
  parameter int unsigned BPV_W = 16,
  parameter int unsigned ERR_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_bpv,
  input  logic       evt_crc,
  input  logic       evt_oof,
  input  logic       evt_fe_main,
  input  logic       evt_fe_sig,
  input  logic       los,
  input  logic       esf_mode,
  input  logic       fe_both,
  input  logic       auto_clr,
  input  logic [3:0] irq_mask,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  // named internal events, visible to assertions
  logic [LEC_N-1:0]               acc;
  logic                           crc_hold;
  logic [LEC_N-1:0]               ld;
  logic [LEC_N-1:0]               hits;
  logic [LEC_N-1:0]               sticky;
  logic                           rd_clr;
  logic [LEC_SLOT-1:0]            ld_bpv_val;
  logic [LEC_BYTE-1:0]            ld_byte;
  logic [LEC_SLOT-1:0]            bpv_q;
  logic [LEC_N-2:0][LEC_BYTE-1:0] err_q;

  lec_evt_gate u_gate (
    .evt_bpv     (evt_bpv),
    .evt_crc     (evt_crc),
    .evt_oof     (evt_oof),
    .evt_fe_main (evt_fe_main),
    .evt_fe_sig  (evt_fe_sig),
    .los         (los),
    .esf_mode    (esf_mode),
    .fe_both     (fe_both),
    .acc         (acc),
    .crc_hold    (crc_hold)
  );

  for (genvar g = 0; g < LEC_N; g++) begin : g_cnt
    localparam int unsigned W = (g == IX_BPV) ? BPV_W : ERR_W;
    logic [W-1:0] ldv;
    logic [W-1:0] q;
    logic         hold_g;
    if (g == IX_BPV) begin : g_wide
      assign ldv    = W'(ld_bpv_val);
      assign bpv_q  = LEC_SLOT'(q);
      assign hold_g = 1'b0;
    end else begin : g_narrow
      assign ldv        = W'(ld_byte);
      assign err_q[g-1] = LEC_BYTE'(q);
      assign hold_g     = (g == IX_CRC) ? crc_hold : 1'b0;
    end
    lec_sat_counter #(.W(W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold_g),
      .clr    (rd_clr),
      .evt    (acc[g]),
      .ld     (ld[g]),
      .ld_val (ldv),
      .q      (q),
      .hit    (hits[g])
    );
  end

  lec_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .auto_clr   (auto_clr),
    .bpv_q      (bpv_q),
    .err_q      (err_q),
    .hits       (hits),
    .ld         (ld),
    .ld_bpv_val (ld_bpv_val),
    .ld_byte    (ld_byte),
    .rd_clr     (rd_clr),
    .rdata      (reg_rdata),
    .sticky     (sticky)
  );

  assign irq = |(sticky & irq_mask);

  assert_irq_needs_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sticky != '0));

  assert_los_oof_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !reg_wr && !rd_clr) |=> $stable(err_q[IX_OOF-1]));

  assert_los_fe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !reg_wr && !rd_clr) |=> $stable(err_q[IX_FE-1]));

  assert_sf_crc_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_mode |=> (err_q[IX_CRC-1] == '0));
endmodule

// File: tb/test_line_err_counters.sv
module test_line_err_counters;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_bpv = 0, evt_crc = 0, evt_oof = 0, evt_fe_main = 0, evt_fe_sig = 0;
  logic       los = 0, esf_mode = 1, fe_both = 0, auto_clr = 0;
  logic [3:0] irq_mask = 4'h0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_cnt[4];
  int m_stage = 0, m_shadow = 0, m_rdata = 0, m_sticky = 0;

  always #10 clk = ~clk;

  line_err_counters i_line_err_counters (
    .clk(clk), .rst_n(rst_n), .evt_bpv(evt_bpv), .evt_crc(evt_crc), .evt_oof(evt_oof),
    .evt_fe_main(evt_fe_main), .evt_fe_sig(evt_fe_sig), .los(los), .esf_mode(esf_mode),
    .fe_both(fe_both), .auto_clr(auto_clr), .irq_mask(irq_mask), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic upd(inout int v, input bit hold, input bit ld, input int ldv,
                     input bit ev, input bit clr, input int maxv, output bit hit);
    int b;
    hit = 0;
    if (hold) v = 0;
    else if (ld) v = ldv;
    else begin
      b = clr ? 0 : v;
      if (ev) begin
        if (b == maxv) hit = 1;
        else b = b + 1;
      end
      v = b;
    end
  endtask

  task automatic model_step();
    bit clr, h0, h1, h2, h3;
    int lim;
    clr = reg_rd && auto_clr;
    if (reg_rd) begin
      case (reg_addr)
        3'd0: m_rdata = m_cnt[0] / 256;
        3'd1: m_rdata = m_shadow;
        3'd2: m_rdata = m_cnt[1];
        3'd3: m_rdata = m_cnt[2];
        3'd4: m_rdata = m_cnt[3];
        3'd5: m_rdata = m_sticky;
        default: m_rdata = 0;
      endcase
      if (reg_addr == 3'd0) m_shadow = m_cnt[0] % 256;
    end
    lim = 65535;
    upd(m_cnt[0], 0, reg_wr && reg_addr == 3'd0, reg_wdata * 256 + m_stage,
        evt_bpv, clr, lim, h0);
    upd(m_cnt[1], !esf_mode, reg_wr && reg_addr == 3'd2, reg_wdata,
        evt_crc && !los, clr, 255, h1);
    upd(m_cnt[2], 0, reg_wr && reg_addr == 3'd3, reg_wdata,
        evt_oof && !los, clr, 255, h2);
    upd(m_cnt[3], 0, reg_wr && reg_addr == 3'd4, reg_wdata,
        !los && (evt_fe_main || (evt_fe_sig && fe_both && !esf_mode)), clr, 255, h3);
    if (reg_wr && reg_addr == 3'd1) m_stage = reg_wdata;
    if (reg_rd && reg_addr == 3'd5) m_sticky = 0;
    m_sticky = m_sticky | {h3, h2, h1, h0};
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R12 model rdata", reg_rdata, m_rdata);
    check("R4 model irq", irq, (m_sticky & irq_mask) != 0);
    {evt_bpv, evt_crc, evt_oof, evt_fe_main, evt_fe_sig} = '0;
    reg_wr = 0;
    reg_rd = 0;
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(d);
    cyc();
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    reg_rd = 1; reg_addr = 3'(a);
    cyc();
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    foreach (m_cnt[i]) m_cnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // reset state
    rd(0, 8'h00, "R12 reset bpv hi");
    rd(5, 8'h00, "R12 reset status");
    check("R4 reset irq", irq, 0);
    // two-byte preset
    wr(1, 8'hFD);
    rd(0, 8'h00, "R6 low write alone");
    rd(1, 8'h00, "R6 low write alone lo");
    wr(0, 8'hFF);
    evt_bpv = 1; cyc();
    evt_bpv = 1; cyc();
    evt_bpv = 1; cyc();
    rd(0, 8'hFF, "R1 bpv hold hi");
    rd(1, 8'hFF, "R1 bpv hold lo");
    rd(5, 8'h01, "R3 bpv sticky");
    rd(5, 8'h00, "R3 sticky cleared");
    // interrupt
    irq_mask = 4'h1;
    evt_bpv = 1; cyc();
    check("R4 irq raised", irq, 1);
    rd(5, 8'h01, "R3 sticky again");
    check("R4 irq dropped", irq, 0);
    irq_mask = 4'h0;
    // crc counting and superframe hold
    for (int i = 0; i < 5; i++) begin evt_crc = 1; cyc(); end
    rd(2, 8'h05, "R2 crc count");
    esf_mode = 0; cyc();
    rd(2, 8'h00, "R9 crc held");
    wr(2, 8'h07);
    rd(2, 8'h00, "R9 crc write ignored");
    evt_crc = 1; cyc();
    rd(2, 8'h00, "R9 crc event ignored");
    esf_mode = 1;
    // loss of sync gating
    wr(1, 0); wr(0, 0);
    los = 1;
    evt_bpv = 1; evt_crc = 1; evt_oof = 1; evt_fe_main = 1; cyc();
    los = 0;
    rd(0, 8'h00, "R8 bpv hi");
    rd(1, 8'h01, "R8 bpv counts in los");
    rd(2, 8'h00, "R8 crc gated");
    rd(3, 8'h00, "R8 oof gated");
    rd(4, 8'h00, "R8 fe gated");
    // frame-bit sources
    esf_mode = 0; fe_both = 0;
    evt_fe_main = 1; cyc();
    evt_fe_sig = 1; cyc();
    rd(4, 8'h01, "R10 sf main only");
    fe_both = 1;
    evt_fe_sig = 1; cyc();
    rd(4, 8'h02, "R10 sf both");
    esf_mode = 1;
    evt_fe_sig = 1; cyc();
    rd(4, 8'h02, "R10 esf sig ignored");
    evt_fe_main = 1; cyc();
    rd(4, 8'h03, "R10 esf main");
    fe_both = 0;
    // low byte latched by high read
    rd(0, 8'h00, "R7 hi read");
    evt_bpv = 1; cyc();
    rd(1, 8'h01, "R7 latched lo");
    rd(0, 8'h00, "R7 hi reread");
    rd(1, 8'h02, "R7 new latched lo");
    // 8-bit saturation
    wr(3, 8'hFE);
    evt_oof = 1; cyc();
    evt_oof = 1; cyc();
    rd(3, 8'hFF, "R1 oof hold");
    rd(5, 8'h04, "R3 oof sticky");
    // write beats event
    evt_oof = 1; wr(3, 8'h0A);
    rd(3, 8'h0A, "R11 write wins");
    // read snapshot
    evt_oof = 1; rd(3, 8'h0A, "R12 snapshot");
    rd(3, 8'h0B, "R12 event kept");
    // clear on read
    auto_clr = 1;
    evt_oof = 1; rd(3, 8'h0B, "R5 clr read value");
    auto_clr = 0;
    rd(4, 8'h00, "R5 fe cleared");
    rd(3, 8'h01, "R5 event kept");
    rd(3, 8'h01, "R5 no clr when off");
    rd(0, 8'h00, "R5 bpv cleared hi");
    rd(1, 8'h00, "R5 bpv cleared lo");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule